// File: doc/BRIEF.md
# Processor status register unit

This block keeps the eight-bit status word of a small eight-bit processor core. It merges two sources of change into one register. The first is an ordinary register write from the data bus. The second is the set of hardware updates that follow each instruction: the arithmetic flags (zero, digit carry, carry) and the power/reset flags (time-out, power-down).

The decoder supplies an instruction class, and the ALU supplies its operands and result. The block works out which flags that class affects and computes their new values from the operands and result. A watchdog time-out strobe comes from outside.

The register value is presented as a whole. Its bank-select fields are also brought out on their own: a two-bit bank number for direct addressing and a one-bit bank-pair select for indirect addressing.

Bit layout, MSB to LSB: bit 7 indirect bank select, bits 6:5 direct bank number, bit 4 time-out flag, bit 3 power-down flag, bit 2 zero, bit 1 digit carry, bit 0 carry.

Instruction class encoding on `op_cls`:

| Code | Class |
|------|-------|
| 0 | none |
| 1 | add |
| 2 | subtract |
| 3 | logic |
| 4 | rotate right through carry |
| 5 | rotate left through carry |
| 6 | clear watchdog |
| 7 | sleep |

Top module: `psr_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the register becomes 8'h18: bank fields 0, time-out 1, power-down 1, and zero, digit carry and carry all 0.
- R2: A write takes effect only when `wr_en` is high and `wr_addr[6:0]` equals 7'h03. The register therefore answers at 9'h003, 9'h083, 9'h103 and 9'h183. A write to any other address leaves the register unchanged.
- R3: Bits 4 and 3 are never changed by write data.
- R4: For add (code 1), the zero flag is set exactly when `alu_res` is 0. Digit carry is the carry out of `opa[3:0]+opb[3:0]`, and carry is the carry out of `opa+opb`.
- R5: For subtract (code 2, `opa-opb`), zero is set exactly when `alu_res` is 0. Carry is 1 when `opa>=opb`. Digit carry is 1 when `opa[3:0]>=opb[3:0]`. In both cases 1 means no borrow.
- R6: For logic (code 3), zero is set exactly when `alu_res` is 0, and digit carry and carry keep their values.
- R7: For rotate right (code 4), carry takes `opa[0]`. For rotate left (code 5), carry takes `opa[7]`. Zero and digit carry keep their values.
- R8: When a class from codes 1 to 5 coincides with a status write, write data is ignored for bits 2:0. Flags the class affects take their computed values, and the other flags among bits 2:0 keep their values. Bits 7:5 still take write data; for example, clearing the register through a logic op gives 000uu1uu.
- R9: With a class that affects no arithmetic flag (codes 0, 6, 7), a status write loads bits 7:5 and 2:0 from `wr_data`.
- R10: Clear watchdog sets time-out and power-down to 1. Sleep sets time-out to 1 and power-down to 0. A `wdt_timeout` pulse clears time-out to 0, and it wins over clear watchdog or sleep in the same cycle.
- R11: `rp_bank` always equals `status[6:5]` and `irp_bank` always equals `status[7]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 9 | Write address |
| wr_data | input | 8 | Write data |
| op_cls | input | 3 | Instruction class (see encoding above) |
| opa | input | 8 | First ALU operand (source for rotates) |
| opb | input | 8 | Second ALU operand |
| alu_res | input | 8 | ALU result |
| wdt_timeout | input | 1 | Watchdog time-out event |
| status | output | 8 | Status register value |
| rp_bank | output | 2 | Direct-addressing bank number |
| irp_bank | output | 1 | Indirect-addressing bank-pair select |

## Verification
The bench targets the carry boundaries.

- A nibble or byte that wraps exactly at its carry boundary catches a design that takes digit carry from the wrong bit or has the borrow polarity inverted.
- Equal operands on subtract catch a design that reports a borrow where none occurs.
- A clear through a logic op aimed at the register catches a design that lets write data reach zero, digit carry or carry. Such a design would end with zero reading 0.
- Writes at every mirror address, and at one address that only shares low bits with them, catch a wrong address decode.
- Sleep combined with a time-out and a write catches a design that lets software or the wrong event own the power flags.

// File: rtl/psr_pkg.sv
// Shared types for the status register unit.
package psr_pkg;

    parameter int W = 8;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_ADD   = 3'd1,
        OP_SUB   = 3'd2,
        OP_LOGIC = 3'd3,
        OP_RRC   = 3'd4,
        OP_RLC   = 3'd5,
        OP_CLRWD = 3'd6,
        OP_SLEEP = 3'd7
    } op_cls_t;

    // Bit positions within the status word; neighbours decode these.
    localparam int B_IRP = 7;
    localparam int B_RP1 = 6;
    localparam int B_RP0 = 5;
    localparam int B_TO  = 4;
    localparam int B_PD  = 3;
    localparam int B_Z   = 2;
    localparam int B_DC  = 1;
    localparam int B_C   = 0;

endpackage

// File: rtl/psr_flag_gen.sv
// Arithmetic flag generator.
// Purpose: decides which of zero / digit carry / carry the current
// instruction class updates, and computes their new values.
// Assumes: opa/opb are the ALU operands and alu_res is the ALU result for
// the same cycle. Subtract is taken as opa - opb. Purely combinational.
module psr_flag_gen
    import psr_pkg::*;
#(
    parameter int DW  = W,
    parameter int NIB = DW / 2
) (
    input  op_cls_t         op,
    input  logic [DW-1:0]   opa,
    input  logic [DW-1:0]   opb,
    input  logic [DW-1:0]   res,
    output logic            z_upd,
    output logic            dc_upd,
    output logic            c_upd,
    output logic            z_val,
    output logic            dc_val,
    output logic            c_val
);

    logic [DW:0]  add_full;
    logic [NIB:0] add_nib;
    logic [DW:0]  sub_full;
    logic [NIB:0] sub_nib;

    // Adders: subtract uses the two's complement of opb, so carry = no borrow.
    always_comb begin
        add_full = {1'b0, opa} + {1'b0, opb};
        add_nib  = {1'b0, opa[NIB-1:0]} + {1'b0, opb[NIB-1:0]};
        sub_full = {1'b0, opa} + {1'b0, ~opb} + {{DW{1'b0}}, 1'b1};
        sub_nib  = {1'b0, opa[NIB-1:0]} + {1'b0, ~opb[NIB-1:0]} + {{NIB{1'b0}}, 1'b1};
    end

    // Per-class selection of update enables and flag values.
    always_comb begin
        z_upd  = 1'b0;
        dc_upd = 1'b0;
        c_upd  = 1'b0;
        z_val  = (res == '0);
        dc_val = 1'b0;
        c_val  = 1'b0;
        unique case (op)
            OP_ADD: begin
                z_upd  = 1'b1;
                dc_upd = 1'b1;
                c_upd  = 1'b1;
                dc_val = add_nib[NIB];
                c_val  = add_full[DW];
            end
            OP_SUB: begin
                z_upd  = 1'b1;
                dc_upd = 1'b1;
                c_upd  = 1'b1;
                dc_val = sub_nib[NIB];
                c_val  = sub_full[DW];
            end
            OP_LOGIC: z_upd = 1'b1;
            OP_RRC: begin
                c_upd = 1'b1;
                c_val = opa[0];
            end
            OP_RLC: begin
                c_upd = 1'b1;
                c_val = opa[DW-1];
            end
            default: ;
        endcase
    end

    // Immediate checks on the update enables.
    always_comb begin
        if (op == OP_LOGIC)
            AST_LOGIC_ZONLY: assert (!dc_upd && !c_upd);               // R6
        if (op == OP_RRC || op == OP_RLC)
            AST_ROT_CONLY: assert (!z_upd && !dc_upd);                 // R7
    end

endmodule

// File: rtl/psr_pwr_flags.sv
// Power/reset flag holder (time-out and power-down).
// Purpose: these two bits are driven only by events, never by bus writes.
// Assumes: wdt_timeout is a one-cycle strobe. It takes priority over
// clear-watchdog and sleep for the time-out bit.
module psr_pwr_flags
    import psr_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  op_cls_t op,
    input  logic    wdt_timeout,
    output logic    to_flag,
    output logic    pd_flag
);

    // Event-driven update of time-out and power-down; reset sets both.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            to_flag <= 1'b1;
            pd_flag <= 1'b1;
        end else begin
            if (op == OP_CLRWD) begin
                to_flag <= 1'b1;
                pd_flag <= 1'b1;
            end else if (op == OP_SLEEP) begin
                to_flag <= 1'b1;
                pd_flag <= 1'b0;
            end
            if (wdt_timeout)
                to_flag <= 1'b0;
        end
    end

    AST_WDT_CLEARS_TO: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_timeout |=> !to_flag);                                     // R10
    AST_SLEEP_PD: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SLEEP) |=> !pd_flag);                                // R10
    AST_CLRWD_PD: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CLRWD) |=> pd_flag);                                 // R10

endmodule

// File: rtl/psr_unit.sv
// Processor status register unit (top).
// Purpose: holds the 8-bit status word. Bus writes and hardware flag
// updates merge here, and the bank-select fields are exported.
// Assumes: synchronous active-low reset. The register is decoded by the
// low address bits only, so it appears once in every bank.
module psr_unit
    import psr_pkg::*;
#(
    parameter int          AW       = 9,
    parameter int          BANK_BITS = 7,
    parameter logic [6:0]  REG_OFS  = 7'h03
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [2:0]    op_cls,
    input  logic [W-1:0]  opa,
    input  logic [W-1:0]  opb,
    input  logic [W-1:0]  alu_res,
    input  logic          wdt_timeout,
    output logic [W-1:0]  status,
    output logic [1:0]    rp_bank,
    output logic          irp_bank
);

    localparam logic [2:0] BANK_RST = 3'b000;

    op_cls_t     op;
    logic        wr_hit;
    logic        z_upd, dc_upd, c_upd;
    logic        z_val, dc_val, c_val;
    logic        to_flag, pd_flag;
    logic [2:0]  bank_q;
    logic        z_q, dc_q, c_q;

    assign op = op_cls_t'(op_cls);

    // Address decode: any bank, fixed offset within the bank.
    assign wr_hit = wr_en && (wr_addr[BANK_BITS-1:0] == REG_OFS[BANK_BITS-1:0]);

    psr_flag_gen #(.DW(W)) u_flags (
        .op     (op),
        .opa    (opa),
        .opb    (opb),
        .res    (alu_res),
        .z_upd  (z_upd),
        .dc_upd (dc_upd),
        .c_upd  (c_upd),
        .z_val  (z_val),
        .dc_val (dc_val),
        .c_val  (c_val)
    );

    psr_pwr_flags u_pwr (
        .clk         (clk),
        .rst_n       (rst_n),
        .op          (op),
        .wdt_timeout (wdt_timeout),
        .to_flag     (to_flag),
        .pd_flag     (pd_flag)
    );

    // Bank-select bits: plain writable storage.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bank_q <= BANK_RST;
        else if (wr_hit)
            bank_q <= wr_data[B_IRP:B_RP0];
    end

    // Arithmetic flags. Any flag-affecting class blocks write data;
    // otherwise write data loads them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            z_q  <= 1'b0;
            dc_q <= 1'b0;
            c_q  <= 1'b0;
        end else if (z_upd || dc_upd || c_upd) begin
            if (z_upd)  z_q  <= z_val;
            if (dc_upd) dc_q <= dc_val;
            if (c_upd)  c_q  <= c_val;
        end else if (wr_hit) begin
            z_q  <= wr_data[B_Z];
            dc_q <= wr_data[B_DC];
            c_q  <= wr_data[B_C];
        end
    end

    // Assemble the status word and the exported bank fields.
    assign status   = {bank_q, to_flag, pd_flag, z_q, dc_q, c_q};
    assign rp_bank  = status[B_RP1:B_RP0];
    assign irp_bank = status[B_IRP];

    AST_TOPD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && op != OP_CLRWD && op != OP_SLEEP && !wdt_timeout)
        |=> status[B_TO:B_PD] == $past(status[B_TO:B_PD]));            // R3
    AST_MISS_HOLDS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(status[B_IRP:B_RP0]));                     // R2
    AST_LOGIC_KEEPS_C: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_LOGIC) |=> status[B_DC:B_C] == $past(status[B_DC:B_C])); // R6
    AST_ROT_KEEPS_Z: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_RRC || op == OP_RLC) |=> $stable(status[B_Z]));      // R7
    AST_FLAG_OP_IGNORES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && op == OP_LOGIC && alu_res == '0) |=> status[B_Z]);  // R8

endmodule

// File: tb/tb_psr_unit.sv
// Self-checking bench: table of one-cycle vectors, then directed reset checks.
module tb_psr_unit;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en;
    logic [8:0] wr_addr;
    logic [7:0] wr_data;
    logic [2:0] op_cls;
    logic [7:0] opa, opb, alu_res;
    logic       wdt_timeout;
    logic [7:0] status;
    logic [1:0] rp_bank;
    logic       irp_bank;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    psr_unit dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .op_cls(op_cls), .opa(opa), .opb(opb),
        .alu_res(alu_res), .wdt_timeout(wdt_timeout), .status(status),
        .rp_bank(rp_bank), .irp_bank(irp_bank)
    );

    // Vector: op(3) a(8) b(8) res(8) we(1) addr(9) data(8) wdt(1) exp(8)
    localparam int NV = 17;
    localparam logic [53:0] VEC [NV] = '{
        {3'd1, 8'h0F, 8'h01, 8'h10, 1'b0, 9'h000, 8'h00, 1'b0, 8'h1A}, // R4 nibble carry
        {3'd1, 8'hFF, 8'h01, 8'h00, 1'b0, 9'h000, 8'h00, 1'b0, 8'h1F}, // R4 byte wrap
        {3'd2, 8'h05, 8'h05, 8'h00, 1'b0, 9'h000, 8'h00, 1'b0, 8'h1F}, // R5 equal
        {3'd2, 8'h10, 8'h01, 8'h0F, 1'b0, 9'h000, 8'h00, 1'b0, 8'h19}, // R5 nibble borrow
        {3'd2, 8'h00, 8'h01, 8'hFF, 1'b0, 9'h000, 8'h00, 1'b0, 8'h18}, // R5 full borrow
        {3'd3, 8'h00, 8'h00, 8'h00, 1'b0, 9'h000, 8'h00, 1'b0, 8'h1C}, // R6
        {3'd5, 8'h80, 8'h00, 8'h00, 1'b0, 9'h000, 8'h00, 1'b0, 8'h1D}, // R7 left
        {3'd4, 8'h02, 8'h00, 8'h01, 1'b0, 9'h000, 8'h00, 1'b0, 8'h1C}, // R7 right
        {3'd0, 8'h00, 8'h00, 8'h00, 1'b1, 9'h083, 8'hE7, 1'b0, 8'hFF}, // R9 R3
        {3'd3, 8'h00, 8'h00, 8'h00, 1'b1, 9'h103, 8'h00, 1'b0, 8'h1F}, // R8 clear
        {3'd0, 8'h00, 8'h00, 8'h00, 1'b1, 9'h004, 8'h00, 1'b0, 8'h1F}, // R2 miss
        {3'd0, 8'h00, 8'h00, 8'h00, 1'b1, 9'h183, 8'h40, 1'b0, 8'h58}, // R2 mirror
        {3'd7, 8'h00, 8'h00, 8'h00, 1'b0, 9'h000, 8'h00, 1'b0, 8'h50}, // R10 sleep
        {3'd0, 8'h00, 8'h00, 8'h00, 1'b0, 9'h000, 8'h00, 1'b1, 8'h40}, // R10 timeout
        {3'd6, 8'h00, 8'h00, 8'h00, 1'b0, 9'h000, 8'h00, 1'b0, 8'h58}, // R10 clrwdt
        {3'd7, 8'h00, 8'h00, 8'h00, 1'b1, 9'h003, 8'h18, 1'b1, 8'h00}, // R10 R3
        {3'd1, 8'h01, 8'h01, 8'h02, 1'b1, 9'h003, 8'h27, 1'b0, 8'h20}  // R8 add+write
    };

    function automatic string tag(int i);
        case (i)
            0, 1:     return "R4";
            2, 3, 4:  return "R5";
            5:        return "R6";
            6, 7:     return "R7";
            8:        return "R9";
            9, 16:    return "R8";
            10, 11:   return "R2";
            15:       return "R3";
            default:  return "R10";
        endcase
    endfunction

    task automatic check8(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        wr_en = 1'b0; wr_addr = '0; wr_data = '0; op_cls = 3'd0;
        opa = '0; opb = '0; alu_res = '0; wdt_timeout = 1'b0;
    endtask

    initial begin
        fork
            begin
                repeat (5000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual=hung expected=done");
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        join_none

        idle();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check8("R1", status, 8'h18);
        rst_n = 1'b1;
        @(negedge clk);
        check8("R1", status, 8'h18);

        for (int i = 0; i < NV; i++) begin
            {op_cls, opa, opb, alu_res, wr_en, wr_addr, wr_data, wdt_timeout} = VEC[i][53:8];
            @(negedge clk);
            check8(tag(i), status, VEC[i][7:0]);
            check8("R11", {5'd0, irp_bank, rp_bank}, {5'd0, VEC[i][7:5]});
        end
        idle();

        // R2: write to the 03h mirror, then an address in the same bank that misses.
        wr_en = 1'b1; wr_addr = 9'h003; wr_data = 8'hA0;
        @(negedge clk);
        check8("R2", status, 8'hA0);
        check8("R11", {6'd0, rp_bank}, 8'h01);
        wr_addr = 9'h013; wr_data = 8'h00;
        @(negedge clk);
        check8("R2", status, 8'hA0);
        idle();

        // R1: mid-run reset restores the reset value.
        rst_n = 1'b0;
        @(negedge clk);
        check8("R1", status, 8'h18);
        rst_n = 1'b1;
        @(negedge clk);
        check8("R1", status, 8'h18);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule